// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger-Level Flags

This block buffers bytes between software and a serial bus engine. A transmit FIFO takes bytes that software writes and hands them to the bus engine one pop at a time. A receive FIFO takes bytes that the bus engine delivers and hands them to software. Both FIFOs are 16 bytes deep by default. Software can read the fill count of each FIFO.

Each FIFO has a programmable trigger level and a level flag. The transmit flag reports "room to refill": it is forced to 1 while the transmit fill is at or below its trigger. The receive flag reports "batch ready": it is forced to 1 while the receive fill is at or above its trigger. Software clears a flag by writing 0 to its bit. That clear is overridden on every cycle in which the level condition still holds, so it only sticks once the fill has moved past the trigger. Four sticky bits record a push into a full FIFO and a pop from an empty FIFO.

Top module: `xfp_fifo_pair`

## Requirements
- R1: After synchronous reset, both fill counts are 0, `flags_o` reads 6'b000001 (transmit flag set, everything else clear), and both read-data outputs are 0x00.
- R2: Each FIFO returns bytes in the order they were accepted. Each fill output equals the number of bytes held, up to 16.
- R3: The transmit trigger code `cfg_tx_lvl` selects 0, 4, 8 or 14 bytes for codes 0, 1, 2 and 3. `flags_o[0]` is forced to 1 whenever the transmit fill is less than or equal to that trigger.
- R4: Writing 0 to `flags_o[0]` has no effect while the transmit fill is at or below the trigger. Once the fill is above the trigger, the clear takes effect and the flag stays 0 until the fill falls back to the trigger.
- R5: The receive trigger is `cfg_rx_lvl` + 1 bytes. `flags_o[1]` is forced to 1 whenever the receive fill is at or above it. A 0-write clear is ignored while that holds, and sticks once the fill is below it.
- R6: Flag bits are cleared by a `sw_flag_wr` cycle that writes 0 to the bit. Writing 1 to a bit leaves it unchanged. The bit layout is: 0 = transmit level, 1 = receive level, 2 = transmit overflow, 3 = receive overflow, 4 = transmit underflow, 5 = receive underflow.
- R7: A push into a full FIFO with no pop in the same cycle is dropped. The fill stays 16 and the FIFO's overflow bit becomes 1 and stays 1 until it is cleared.
- R8: A pop from an empty FIFO presents 0x00 on the read data and sets that FIFO's sticky underflow bit.
- R9: A push and a pop on the same FIFO in the same cycle leave its fill unchanged, including when the FIFO is full. When the FIFO is empty, the push is kept, the pop returns 0x00 and the underflow bit is set.
- R10: The flags are evaluated from the fill that results from the cycle's push and pop, and are visible on `flags_o` in the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_tx_push | input | 1 | Software pushes `sw_tx_byte` into the transmit FIFO |
| sw_tx_byte | input | 8 | Transmit byte from software |
| sw_rx_pop | input | 1 | Software pops the receive FIFO head |
| sw_rx_byte | output | 8 | Receive FIFO head (0x00 when empty) |
| cfg_tx_lvl | input | 2 | Transmit trigger code |
| cfg_rx_lvl | input | 4 | Receive trigger code (trigger = code + 1) |
| sw_flag_wr | input | 1 | Flag clear write strobe |
| sw_flag_wdata | input | 6 | Clear data; a 0 bit clears that flag |
| flags_o | output | 6 | Level flags and sticky error bits |
| tx_fill_o | output | 5 | Transmit FIFO byte count |
| rx_fill_o | output | 5 | Receive FIFO byte count |
| bus_tx_pop | input | 1 | Bus engine pops the transmit FIFO head |
| bus_tx_byte | output | 8 | Transmit FIFO head (0x00 when empty) |
| bus_rx_push | input | 1 | Bus engine pushes `bus_rx_byte` |
| bus_rx_byte | input | 8 | Receive byte from the bus engine |

## Verification
The read-data outputs are combinational from the FIFO head. They are compared at the clock edge that consumes the pop, before the registers update. Fill counts and every bit of `flags_o` are registered, so they are due one edge after the strobe. The bench drives each stimulus on a falling edge, waits for the next rising edge plus a small delay, and only then compares counts and flags. Its scoreboard queues are updated at that same delayed point, so a push and a pop in the same cycle are judged against the state before the edge.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
    localparam int FLAG_W   = 6;
    localparam int F_TXLVL  = 0;
    localparam int F_RXLVL  = 1;
    localparam int F_TXOVF  = 2;
    localparam int F_RXOVF  = 3;
    localparam int F_TXUNF  = 4;
    localparam int F_RXUNF  = 5;

    // transmit trigger code to byte count
    function automatic int unsigned tx_trig_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/xfp_fifo_core.sv
module xfp_fifo_core #(
    parameter  int DEPTH = 16,
    parameter  int WIDTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [CW-1:0]    count_o,
    output logic [CW-1:0]    count_next_o,
    output logic             drop_o,
    output logic             starve_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic empty, full, pop_ok, push_ok;

    always_comb begin
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == FULL_CNT);
        pop_ok  = pop_i && !empty;
        push_ok = push_i && (!full || pop_ok);
        st_d    = st_q;
        if (push_ok) st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        if (pop_ok)  st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst && push_ok) mem_q[st_q.wr_ptr] <= wdata_i;
    end

    assign rdata_o      = empty ? '0 : mem_q[st_q.rd_ptr];
    assign count_o      = st_q.cnt;
    assign count_next_o = st_d.cnt;
    assign drop_o       = push_i && !push_ok;
    assign starve_o     = pop_i && empty;

    // R2: fill never exceeds depth
    a_r2_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        count_o <= FULL_CNT);
    // R9: simultaneous push and pop on a non-empty FIFO keeps the fill
    a_r9_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && count_o != '0) |=> $stable(count_o));
endmodule

// File: rtl/xfp_trig_flag.sv
module xfp_trig_flag #(
    parameter int CW          = 5,
    parameter bit AT_OR_ABOVE = 1'b0,
    parameter bit RST_VAL     = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] fill_next_i,
    input  logic [CW-1:0] trig_i,
    input  logic          clr_i,
    output logic          flag_o
);
    logic hit;
    logic flag_d, flag_q;

    generate
        if (AT_OR_ABOVE) begin : g_ge
            always_comb hit = (fill_next_i >= trig_i);
        end else begin : g_le
            always_comb hit = (fill_next_i <= trig_i);
        end
    endgenerate

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (hit)   flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= RST_VAL;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/xfp_fifo_pair.sv
module xfp_fifo_pair
    import xfp_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_tx_push,
    input  logic [7:0]        sw_tx_byte,
    input  logic              sw_rx_pop,
    output logic [7:0]        sw_rx_byte,
    input  logic [1:0]        cfg_tx_lvl,
    input  logic [3:0]        cfg_rx_lvl,
    input  logic              sw_flag_wr,
    input  logic [FLAG_W-1:0] sw_flag_wdata,
    output logic [FLAG_W-1:0] flags_o,
    output logic [CW-1:0]     tx_fill_o,
    output logic [CW-1:0]     rx_fill_o,
    input  logic              bus_tx_pop,
    output logic [7:0]        bus_tx_byte,
    input  logic              bus_rx_push,
    input  logic [7:0]        bus_rx_byte
);
    typedef struct packed {
        logic tx_ovf;
        logic rx_ovf;
        logic tx_unf;
        logic rx_unf;
    } sticky_t;

    sticky_t sk_d, sk_q;
    logic [CW-1:0] tx_next, rx_next, tx_trig, rx_trig;
    logic tx_drop, tx_starve, rx_drop, rx_starve;
    logic tx_lvl, rx_lvl;
    logic [FLAG_W-1:0] clr_vec;

    xfp_fifo_core #(.DEPTH(DEPTH), .WIDTH(8)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push_i(sw_tx_push), .wdata_i(sw_tx_byte),
        .pop_i(bus_tx_pop), .rdata_o(bus_tx_byte),
        .count_o(tx_fill_o), .count_next_o(tx_next),
        .drop_o(tx_drop), .starve_o(tx_starve)
    );

    xfp_fifo_core #(.DEPTH(DEPTH), .WIDTH(8)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push_i(bus_rx_push), .wdata_i(bus_rx_byte),
        .pop_i(sw_rx_pop), .rdata_o(sw_rx_byte),
        .count_o(rx_fill_o), .count_next_o(rx_next),
        .drop_o(rx_drop), .starve_o(rx_starve)
    );

    always_comb begin
        tx_trig = CW'(tx_trig_bytes(cfg_tx_lvl));
        rx_trig = CW'(cfg_rx_lvl) + 1'b1;
        clr_vec = sw_flag_wr ? ~sw_flag_wdata : '0;
    end

    xfp_trig_flag #(.CW(CW), .AT_OR_ABOVE(1'b0), .RST_VAL(1'b1)) u_tx_flag (
        .clk(clk), .rst(rst), .fill_next_i(tx_next), .trig_i(tx_trig),
        .clr_i(clr_vec[F_TXLVL]), .flag_o(tx_lvl)
    );

    xfp_trig_flag #(.CW(CW), .AT_OR_ABOVE(1'b1), .RST_VAL(1'b0)) u_rx_flag (
        .clk(clk), .rst(rst), .fill_next_i(rx_next), .trig_i(rx_trig),
        .clr_i(clr_vec[F_RXLVL]), .flag_o(rx_lvl)
    );

    always_comb begin
        sk_d = sk_q;
        if (clr_vec[F_TXOVF]) sk_d.tx_ovf = 1'b0;
        if (clr_vec[F_RXOVF]) sk_d.rx_ovf = 1'b0;
        if (clr_vec[F_TXUNF]) sk_d.tx_unf = 1'b0;
        if (clr_vec[F_RXUNF]) sk_d.rx_unf = 1'b0;
        if (tx_drop)   sk_d.tx_ovf = 1'b1;
        if (rx_drop)   sk_d.rx_ovf = 1'b1;
        if (tx_starve) sk_d.tx_unf = 1'b1;
        if (rx_starve) sk_d.rx_unf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) sk_q <= '0;
        else     sk_q <= sk_d;
    end

    always_comb begin
        flags_o          = '0;
        flags_o[F_TXLVL] = tx_lvl;
        flags_o[F_RXLVL] = rx_lvl;
        flags_o[F_TXOVF] = sk_q.tx_ovf;
        flags_o[F_RXOVF] = sk_q.rx_ovf;
        flags_o[F_TXUNF] = sk_q.tx_unf;
        flags_o[F_RXUNF] = sk_q.rx_unf;
    end

    // R3: transmit flag is 1 while the fill sits at or below a steady trigger
    a_r3_tx_flag_at_level: assert property (@(posedge clk) disable iff (rst)
        ($stable(cfg_tx_lvl) && tx_fill_o <= tx_trig) |-> flags_o[F_TXLVL]);
    // R5: receive flag is 1 while the fill sits at or above a steady trigger
    a_r5_rx_flag_at_level: assert property (@(posedge clk) disable iff (rst)
        ($stable(cfg_rx_lvl) && rx_fill_o >= rx_trig) |-> flags_o[F_RXLVL]);
    // R6: writing 1 never lowers a set bit
    a_r6_one_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        (sw_flag_wr && (sw_flag_wdata & flags_o) == flags_o) |=>
        ((flags_o & $past(flags_o)) == $past(flags_o)));
    // R7: push into a full transmit FIFO without a pop is dropped
    a_r7_tx_overflow: assert property (@(posedge clk) disable iff (rst)
        (sw_tx_push && !bus_tx_pop && tx_fill_o == CW'(DEPTH)) |=>
        (tx_fill_o == CW'(DEPTH) && flags_o[F_TXOVF]));
    // R8: pop from an empty receive FIFO sets its underflow bit
    a_r8_rx_underflow: assert property (@(posedge clk) disable iff (rst)
        (sw_rx_pop && rx_fill_o == '0) |=> flags_o[F_RXUNF]);
endmodule

// File: tb/xfp_fifo_pair_tb.sv
`timescale 1ns/1ps
module xfp_fifo_pair_tb_top;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_tx_push = 0, sw_rx_pop = 0, sw_flag_wr = 0;
    logic bus_tx_pop = 0, bus_rx_push = 0;
    logic [7:0] sw_tx_byte = 0, bus_rx_byte = 0;
    logic [1:0] cfg_tx_lvl = 2'd1;
    logic [3:0] cfg_rx_lvl = 4'd3;
    logic [5:0] sw_flag_wdata = '1;
    logic [7:0] sw_rx_byte, bus_tx_byte;
    logic [5:0] flags_o;
    logic [CW-1:0] tx_fill_o, rx_fill_o;

    int n_checks = 0;
    int n_errs = 0;
    byte unsigned txq[$];
    byte unsigned rxq[$];

    xfp_fifo_pair dut_i (
        .clk(clk), .rst(rst),
        .sw_tx_push(sw_tx_push), .sw_tx_byte(sw_tx_byte),
        .sw_rx_pop(sw_rx_pop), .sw_rx_byte(sw_rx_byte),
        .cfg_tx_lvl(cfg_tx_lvl), .cfg_rx_lvl(cfg_rx_lvl),
        .sw_flag_wr(sw_flag_wr), .sw_flag_wdata(sw_flag_wdata),
        .flags_o(flags_o), .tx_fill_o(tx_fill_o), .rx_fill_o(rx_fill_o),
        .bus_tx_pop(bus_tx_pop), .bus_tx_byte(bus_tx_byte),
        .bus_rx_push(bus_rx_push), .bus_rx_byte(bus_rx_byte)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: compares popped bytes against the scoreboard at the consuming edge
    always @(posedge clk) begin
        if (!rst && bus_tx_pop) begin
            chk("R2/R8 tx byte", bus_tx_byte, (txq.size() > 0) ? txq.pop_front() : 0);
        end
        if (!rst && sw_rx_pop) begin
            chk("R2/R8 rx byte", sw_rx_byte, (rxq.size() > 0) ? rxq.pop_front() : 0);
        end
    end

    // driver: one cycle of strobes; scoreboard updated after the edge
    task automatic step(input bit tp, input byte unsigned td, input bit tpop,
                        input bit rp, input byte unsigned rd, input bit rpop);
        @(negedge clk);
        sw_tx_push = tp; sw_tx_byte = td; bus_tx_pop = tpop;
        bus_rx_push = rp; bus_rx_byte = rd; sw_rx_pop = rpop;
        @(posedge clk);
        #1;
        if (tp && txq.size() < 16) txq.push_back(td);
        if (rp && rxq.size() < 16) rxq.push_back(rd);
        sw_tx_push = 0; bus_tx_pop = 0; bus_rx_push = 0; sw_rx_pop = 0;
    endtask

    task automatic flag_write(input logic [5:0] d);
        @(negedge clk);
        sw_flag_wr = 1'b1; sw_flag_wdata = d;
        @(posedge clk);
        #1;
        sw_flag_wr = 1'b0; sw_flag_wdata = '1;
    endtask

    task automatic chk_fill(input string req);
        chk({req, " tx fill"}, int'(tx_fill_o), txq.size());
        chk({req, " rx fill"}, int'(rx_fill_o), rxq.size());
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk_fill("R1");
        chk("R1 flags", flags_o, 6'b000001);
        chk("R1 tx head", bus_tx_byte, 0);
        chk("R1 rx head", sw_rx_byte, 0);

        // transmit trigger 4 bytes (code 1)
        for (int i = 0; i < 3; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, 0);
        chk_fill("R2");
        chk("R3 tx flag at 3<=4", flags_o[0], 1);
        flag_write(6'b111110);
        chk("R4 clear ignored below trigger", flags_o[0], 1);
        step(1, 8'hA3, 0, 0, 0, 0);
        step(1, 8'hA4, 0, 0, 0, 0);
        chk("R4 flag held above trigger", flags_o[0], 1);
        flag_write(6'b111110);
        chk("R4 clear sticks above trigger", flags_o[0], 0);
        flag_write(6'b111111);
        chk("R6 write one does not set", flags_o[0], 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R10 flag from new fill 4", flags_o[0], 1);
        flag_write(6'b111111);
        chk("R6 write one keeps flag", flags_o, 6'b000001);

        // code 0: trigger 0 bytes
        cfg_tx_lvl = 2'd0;
        flag_write(6'b111110);
        chk("R3 code0 clear sticks at fill 4", flags_o[0], 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0);
        chk("R3 code0 fill 1 stays clear", flags_o[0], 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R3 code0 set when empty", flags_o[0], 1);

        // code 3: trigger 14 bytes
        cfg_tx_lvl = 2'd3;
        for (int i = 0; i < 14; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0);
        flag_write(6'b111110);
        chk("R3 code3 forced at 14", flags_o[0], 1);
        step(1, 8'h1E, 0, 0, 0, 0);
        flag_write(6'b111110);
        chk("R3 code3 clear sticks at 15", flags_o[0], 0);
        cfg_tx_lvl = 2'd2;
        step(1, 8'h1F, 0, 0, 0, 0);
        chk("R3 code2 fill 16 stays clear", flags_o[0], 0);
        step(1, 8'hEE, 0, 0, 0, 0);
        chk_fill("R7");
        chk("R7 tx overflow bit", flags_o[2], 1);
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, 0);
        chk_fill("R2 drained");
        chk("R3 code2 set when drained", flags_o[0], 1);
        step(0, 0, 1, 0, 0, 0);
        chk("R8 tx underflow bit", flags_o[4], 1);
        flag_write(6'b101011);
        chk("R6 sticky bits cleared", flags_o, 6'b000001);

        // receive trigger 4 bytes (code 3)
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 8'h50 + 8'(i), 0);
        chk("R5 rx flag below trigger", flags_o[1], 0);
        step(0, 0, 0, 1, 8'h53, 0);
        chk("R5 rx flag at trigger", flags_o[1], 1);
        flag_write(6'b111101);
        chk("R5 clear ignored at trigger", flags_o[1], 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R5 flag held below trigger", flags_o[1], 1);
        flag_write(6'b111101);
        chk("R5 clear sticks below trigger", flags_o[1], 0);
        step(0, 0, 0, 1, 8'h54, 0);
        chk("R10 rx flag from new fill", flags_o[1], 1);
        step(0, 0, 0, 1, 8'h55, 1);
        chk_fill("R9 push+pop");
        for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 8'h60 + 8'(i), 0);
        chk_fill("R2 rx full");
        step(0, 0, 0, 1, 8'h70, 1);
        chk_fill("R9 full push+pop");
        chk("R9 no overflow on full push+pop", flags_o[3], 0);
        step(0, 0, 0, 1, 8'h71, 0);
        chk("R7 rx overflow bit", flags_o[3], 1);
        chk_fill("R7 rx");
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R8 rx underflow bit", flags_o[5], 1);
        chk_fill("R8 rx drained");

        // empty transmit FIFO: push and pop together
        step(1, 8'hC0, 1, 0, 0, 0);
        chk_fill("R9 empty push+pop");
        chk("R9 underflow on empty push+pop", flags_o[4], 1);
        step(0, 0, 1, 0, 0, 0);
        chk_fill("R9 after drain");

        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule